// File: doc/BRIEF.md
# PCI Target Byte-Lane to Local Bus Translator

This block sits behind a PCI target front end and turns one single-beat target access into at most one cycle on a narrow local bus. The front end presents a 32-bit word, four active-low byte enables, a direction bit and a one-clock start strobe. The block checks the enable pattern against the set that the selected local bus width can carry. It then either runs a strobe/acknowledge cycle on the local bus or ends the access at once. A local cycle drives the two low address bits, a high-byte enable and the active data lanes.

Every accepted start ends in exactly one of three one-clock outcomes. Done means the local cycle finished. For reads, the returned data is steered onto the PCI byte lanes the host enabled. Abort means the pattern is not legal for the bus width, and the front end turns it into a target abort. No-op means no enable was asserted, so nothing runs on the local bus. A width select input chooses between an 8-bit and a 16-bit local bus, and it is sampled with each start.

Top module: `pci_lane_bridge`

## Requirements
- R1: After reset, locStb, doneP, abortP and noopP are 0 and rdData is 0.
- R2: With narrowSel=1, the legal active-low patterns are 1110, 1101, 1011 and 0111. They give locAddr 00, 01, 10 and 11, locBhe=1, the selected byte on locDout[7:0] and locDout[15:8]=0.
- R3: With narrowSel=0, pattern 1100 gives locAddr=00 and 0011 gives locAddr=10. Both set locBhe=0 and drive locDout with wrData[15:0] or wrData[31:16] respectively.
- R4: With narrowSel=0, pattern 1110 gives locAddr=00 and 1011 gives locAddr=10, each with locBhe=1 and the byte on locDout[7:0]. Pattern 1101 gives locAddr=01 and 0111 gives locAddr=11, each with locBhe=0 and the byte on locDout[15:8]. The unused lane is 0.
- R5: An illegal pattern for the selected width with at least one enable asserted pulses abortP in the cycle after the start. locStb is never raised for that access.
- R6: Pattern 1111 pulses noopP in the cycle after the start. It raises neither abortP nor locStb.
- R7: For a legal access, locStb is 1 from the cycle after the start. locAddr, locBhe, locDout and locWr stay unchanged while locStb is 1 and locAck is 0.
- R8: A cycle with locStb=1 and locAck=1 is followed by a cycle with doneP=1 and locStb=0. doneP lasts one clock.
- R9: On a read, rdData at doneP holds, in each enabled byte lane i, locDin[7:0] in 8-bit mode. In 16-bit mode it holds locDin[15:8] for odd i and locDin[7:0] for even i. Disabled lanes are 0, and rdData holds until the next read completes.
- R10: doneP, abortP and noopP are never high together. Each accepted start produces exactly one of them.
- R11: A start while a local cycle is in progress is ignored and produces no outcome. A start in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| narrowSel | input | 1 | 1 = 8-bit local bus, 0 = 16-bit, sampled with startStb |
| startStb | input | 1 | One-clock access start |
| wrEn | input | 1 | 1 = write, 0 = read |
| beN | input | 4 | Active-low PCI byte enables |
| wrData | input | 32 | PCI write word |
| rdData | output | 32 | Steered read word |
| locStb | output | 1 | Local cycle strobe |
| locWr | output | 1 | Local cycle direction |
| locAddr | output | 2 | Local address bits A1:A0 |
| locBhe | output | 1 | High-byte enable, 0 = upper lane active |
| locDout | output | 16 | Local write data lanes |
| locDin | input | 16 | Local read data lanes |
| locAck | input | 1 | Local cycle acknowledge |
| doneP | output | 1 | Access completed pulse |
| abortP | output | 1 | Target abort pulse |
| noopP | output | 1 | Empty access pulse |

## Verification
Two events can fall in the same cycle: the completion of one access and the launch of the next, and a new start with the acknowledge of the cycle in progress. The bench raises startStb in the very cycle doneP is high. It then checks that a fresh strobe appears one clock later with the new lane decode and that doneP does not stretch. It also raises a start together with locAck during a busy cycle and checks that exactly one outcome, the done, results.

// File: rtl/lane_bridge_pkg.sv
package lane_bridge_pkg;
  localparam int PCI_BYTES = 4;
  localparam int LOC_BYTES = 2;
  localparam int PCI_W     = PCI_BYTES * 8;
  localparam int LOC_W     = LOC_BYTES * 8;
  localparam int ADDR_W    = $clog2(PCI_BYTES);

  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} busState_t;

  typedef struct packed {
    logic loadReq;
    logic capRd;
  } ctrlStb_t;
endpackage

// File: rtl/lane_bridge_decode.sv
module lane_bridge_decode
  import lane_bridge_pkg::*;
(
  input  logic                 narrowSel,
  input  logic [PCI_BYTES-1:0] beN,
  output logic                 accLegal,
  output logic                 accEmpty,
  output logic [ADDR_W-1:0]    addr,
  output logic                 bhe,
  output logic [PCI_BYTES-1:0] laneEn
);
  logic single;
  logic pairLo;
  logic pairHi;
  logic [ADDR_W-1:0] idx;

  assign laneEn   = ~beN;
  assign accEmpty = (laneEn == '0);
  assign single   = $onehot(laneEn);
  assign pairLo   = (laneEn == 4'b0011);
  assign pairHi   = (laneEn == 4'b1100);

  always_comb begin
    idx = '0;
    for (int i = 0; i < PCI_BYTES; i++) begin
      if (laneEn[i]) idx = ADDR_W'(i);
    end
  end

  always_comb begin
    if (narrowSel) begin
      accLegal = single;
      addr     = idx;
      bhe      = 1'b1;
    end else begin
      accLegal = single | pairLo | pairHi;
      if (single) begin
        addr = idx;
        bhe  = ~idx[0];
      end else begin
        addr = {pairHi, 1'b0};
        bhe  = 1'b0;
      end
    end
  end
endmodule

// File: rtl/lane_bridge_ctrl.sv
module lane_bridge_ctrl
  import lane_bridge_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startStb,
  input  logic     accLegal,
  input  logic     accEmpty,
  input  logic     locAck,
  output ctrlStb_t stb,
  output logic     locStb,
  output logic     doneP,
  output logic     abortP,
  output logic     noopP
);
  busState_t state;
  logic      takeStart;

  assign takeStart   = (state == ST_IDLE) && startStb;
  assign stb.loadReq = takeStart && accLegal;
  assign stb.capRd   = (state == ST_BUSY) && locAck;
  assign locStb      = (state == ST_BUSY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      doneP  <= 1'b0;
      abortP <= 1'b0;
      noopP  <= 1'b0;
    end else begin
      doneP  <= stb.capRd;
      abortP <= takeStart && !accLegal && !accEmpty;
      noopP  <= takeStart && accEmpty;
      case (state)
        ST_IDLE: if (stb.loadReq) state <= ST_BUSY;
        ST_BUSY: if (locAck) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lane_bridge_dp.sv
module lane_bridge_dp
  import lane_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic              narrowSel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] decAddr,
  input  logic              decBhe,
  input  logic [PCI_BYTES-1:0] decLanes,
  input  logic [PCI_W-1:0]  wrData,
  input  logic [LOC_W-1:0]  locDin,
  output logic [PCI_W-1:0]  rdData,
  output logic              locWr,
  output logic [ADDR_W-1:0] locAddr,
  output logic              locBhe,
  output logic [LOC_W-1:0]  locDout
);
  logic [PCI_BYTES-1:0] laneR;
  logic                 narrowR;
  logic [LOC_W-1:0]     doutNext;
  logic [LOC_W-1:0]     half;
  logic [1:0]           halfMask;
  logic [PCI_W-1:0]     rdNext;

  always_comb begin
    half     = decAddr[1] ? wrData[PCI_W-1:LOC_W] : wrData[LOC_W-1:0];
    halfMask = decAddr[1] ? decLanes[3:2] : decLanes[1:0];
    if (narrowSel) doutNext = {8'h00, wrData[8*decAddr +: 8]};
    else           doutNext = half & {{8{halfMask[1]}}, {8{halfMask[0]}}};
  end

  for (genvar g = 0; g < PCI_BYTES; g++) begin : g_rdLane
    logic [7:0] src;
    assign src = (narrowR || (g % 2 == 0)) ? locDin[7:0] : locDin[15:8];
    assign rdNext[8*g +: 8] = laneR[g] ? src : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      laneR   <= '0;
      narrowR <= 1'b0;
      locWr   <= 1'b0;
      locAddr <= '0;
      locBhe  <= 1'b1;
      locDout <= '0;
      rdData  <= '0;
    end else begin
      if (stb.loadReq) begin
        laneR   <= decLanes;
        narrowR <= narrowSel;
        locWr   <= wrEn;
        locAddr <= decAddr;
        locBhe  <= decBhe;
        locDout <= doutNext;
      end
      if (stb.capRd && !locWr) rdData <= rdNext;
    end
  end
endmodule

// File: rtl/pci_lane_bridge.sv
module pci_lane_bridge
  import lane_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        narrowSel,
  input  logic        startStb,
  input  logic        wrEn,
  input  logic [3:0]  beN,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        locStb,
  output logic        locWr,
  output logic [1:0]  locAddr,
  output logic        locBhe,
  output logic [15:0] locDout,
  input  logic [15:0] locDin,
  input  logic        locAck,
  output logic        doneP,
  output logic        abortP,
  output logic        noopP
);
  ctrlStb_t             stb;
  logic                 accLegal;
  logic                 accEmpty;
  logic [ADDR_W-1:0]    decAddr;
  logic                 decBhe;
  logic [PCI_BYTES-1:0] decLanes;

  lane_bridge_decode u_decode (
    .narrowSel(narrowSel), .beN(beN), .accLegal(accLegal), .accEmpty(accEmpty),
    .addr(decAddr), .bhe(decBhe), .laneEn(decLanes)
  );

  lane_bridge_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .accLegal(accLegal),
    .accEmpty(accEmpty), .locAck(locAck), .stb(stb), .locStb(locStb),
    .doneP(doneP), .abortP(abortP), .noopP(noopP)
  );

  lane_bridge_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .narrowSel(narrowSel), .wrEn(wrEn),
    .decAddr(decAddr), .decBhe(decBhe), .decLanes(decLanes), .wrData(wrData),
    .locDin(locDin), .rdData(rdData), .locWr(locWr), .locAddr(locAddr),
    .locBhe(locBhe), .locDout(locDout)
  );
endmodule

// File: rtl/pci_lane_bridge_chk.sv
module pci_lane_bridge_chk (
  input logic        clk,
  input logic        rstN,
  input logic        startStb,
  input logic        locStb,
  input logic        locAck,
  input logic        locWr,
  input logic [1:0]  locAddr,
  input logic        locBhe,
  input logic [15:0] locDout,
  input logic        doneP,
  input logic        abortP,
  input logic        noopP
);
  // R7: lane outputs hold while the cycle waits
  a_r7_hold_lanes: assert property (@(posedge clk) disable iff (!rstN)
    (locStb && !locAck) |=> (locStb && $stable(locAddr) && $stable(locBhe)
                              && $stable(locDout) && $stable(locWr)));

  // R7: a strobe only rises right after a start
  a_r7_rise_after_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locStb) |-> $past(startStb));

  // R8: acknowledge ends the strobe and yields done
  a_r8_ack_done: assert property (@(posedge clk) disable iff (!rstN)
    (locStb && locAck) |=> (doneP && !locStb));

  // R8: done is a single clock
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP);

  // R5: abort follows a start and never comes with a strobe
  a_r5_abort_nostrobe: assert property (@(posedge clk) disable iff (!rstN)
    abortP |-> (!locStb && $past(startStb)));

  // R6: no-op follows a start and never comes with a strobe
  a_r6_noop_nostrobe: assert property (@(posedge clk) disable iff (!rstN)
    noopP |-> (!locStb && $past(startStb)));

  // R10: outcomes are exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $countones({doneP, abortP, noopP}) <= 1);
endmodule

bind pci_lane_bridge pci_lane_bridge_chk u_chk (
  .clk(clk), .rstN(rstN), .startStb(startStb), .locStb(locStb), .locAck(locAck),
  .locWr(locWr), .locAddr(locAddr), .locBhe(locBhe), .locDout(locDout),
  .doneP(doneP), .abortP(abortP), .noopP(noopP)
);

// File: tb/pci_lane_bridge_tb.sv
module pci_lane_bridge_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        narrowSel = 1'b0;
  logic        startStb = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  beN = 4'hF;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        locStb, locWr, locBhe, doneP, abortP, noopP;
  logic [1:0]  locAddr;
  logic [15:0] locDout;
  logic [15:0] locDin = '0;
  logic        locAck = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pci_lane_bridge u_dut (
    .clk(clk), .rstN(rstN), .narrowSel(narrowSel), .startStb(startStb),
    .wrEn(wrEn), .beN(beN), .wrData(wrData), .rdData(rdData), .locStb(locStb),
    .locWr(locWr), .locAddr(locAddr), .locBhe(locBhe), .locDout(locDout),
    .locDin(locDin), .locAck(locAck), .doneP(doneP), .abortP(abortP), .noopP(noopP)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected decode computed arithmetically from the requirements
  task automatic model(input bit narrow, input logic [3:0] be, input logic [31:0] wd,
                       input logic [15:0] din, output int kind, output logic [1:0] ad,
                       output logic bh, output logic [15:0] dout, output logic [31:0] rd);
    logic [3:0] en;
    int cnt;
    int idx;
    en = ~be; cnt = 0; idx = 0;
    for (int i = 0; i < 4; i++) if (en[i]) begin cnt++; idx = i; end
    ad = 2'(idx); bh = 1'b1; dout = '0; rd = '0;
    if (cnt == 0) kind = 2;
    else if (cnt == 1) begin
      kind = 0;
      if (narrow) dout = {8'h00, wd[8*idx +: 8]};
      else begin
        bh = (idx % 2 == 0);
        dout = (idx % 2 == 1) ? {wd[8*idx +: 8], 8'h00} : {8'h00, wd[8*idx +: 8]};
      end
    end else if (!narrow && (en == 4'b0011 || en == 4'b1100)) begin
      kind = 0; bh = 1'b0;
      ad = (en == 4'b1100) ? 2'b10 : 2'b00;
      dout = (en == 4'b1100) ? wd[31:16] : wd[15:0];
    end else kind = 1;
    for (int i = 0; i < 4; i++)
      if (en[i]) rd[8*i +: 8] = (narrow || i % 2 == 0) ? din[7:0] : din[15:8];
  endtask

  // One access; sampling on negedges. Expected requirement tag chosen per case.
  task automatic run(input bit narrow, input bit wr, input logic [3:0] be,
                     input logic [31:0] wd, input logic [15:0] din, input int waitCyc,
                     input bit busyPoke);
    int kind; logic [1:0] ad; logic bh; logic [15:0] dout; logic [31:0] rd;
    logic [31:0] rdPrev;
    string tag;
    model(narrow, be, wd, din, kind, ad, bh, dout, rd);
    tag = narrow ? "R2" : ((be == 4'b1100 || be == 4'b0011) ? "R3" : "R4");
    rdPrev = rdData;
    narrowSel = narrow; wrEn = wr; beN = be; wrData = wd; startStb = 1'b1;
    @(negedge clk);
    startStb = 1'b0; beN = 4'hF; wrData = '0;
    if (kind == 1) begin
      chk("R5", "abortP", 32'(abortP), 1); chk("R5", "locStb", 32'(locStb), 0);
      chk("R10", "others", 32'({doneP, noopP}), 0);
      @(negedge clk); chk("R5", "abort single", 32'(abortP), 0);
      chk("R5", "no strobe later", 32'(locStb), 0);
    end else if (kind == 2) begin
      chk("R6", "noopP", 32'(noopP), 1); chk("R6", "locStb", 32'(locStb), 0);
      chk("R6", "abortP", 32'(abortP), 0);
      @(negedge clk); chk("R6", "noop single", 32'(noopP), 0);
    end else begin
      chk("R7", "strobe up", 32'(locStb), 1);
      chk(tag, "addr", 32'(locAddr), 32'(ad));
      chk(tag, "bhe", 32'(locBhe), 32'(bh));
      chk(tag, "dout", 32'(locDout), 32'(dout));
      chk("R7", "dir", 32'(locWr), 32'(wr));
      chk("R10", "no outcome", 32'({doneP, abortP, noopP}), 0);
      for (int w = 0; w < waitCyc; w++) begin
        if (busyPoke && w == 0) begin beN = 4'b0101; startStb = 1'b1; end
        @(negedge clk);
        startStb = 1'b0; beN = 4'hF;
        chk("R11", "busy no outcome", 32'({doneP, abortP, noopP}), 0);
        chk("R7", "held addr", 32'({locStb, locAddr, locBhe, locDout}),
            32'({1'b1, ad, bh, dout}));
      end
      locAck = 1'b1; locDin = din;
      @(negedge clk);
      locAck = 1'b0; locDin = '0;
      chk("R8", "done", 32'(doneP), 1); chk("R8", "strobe down", 32'(locStb), 0);
      chk("R10", "excl", 32'({abortP, noopP}), 0);
      chk("R9", "rdData", rdData, wr ? rdPrev : rd);
      @(negedge clk);
      chk("R8", "done single", 32'(doneP), 0);
      chk("R9", "rd hold", rdData, wr ? rdPrev : rd);
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs", 32'({locStb, doneP, abortP, noopP}), 0);
    chk("R1", "reset rdData", rdData, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "idle", 32'({locStb, doneP, abortP, noopP}), 0);

    for (int n = 0; n < 2; n++)
      for (int d = 0; d < 2; d++)
        for (int p = 0; p < 16; p++)
          run(n[0], d[0], 4'(p), 32'hA1B2C3D4 ^ (32'(p) * 32'h01010101),
              16'h5E00 | 16'(p * 7 + n), p % 3, 1'b0);

    // R11: start during busy, also together with ack
    run(1'b0, 1'b0, 4'b0011, 32'h11223344, 16'hBEEF, 2, 1'b1);
    narrowSel = 1'b1; wrEn = 1'b0; beN = 4'b1110; startStb = 1'b1;
    @(negedge clk);
    beN = 4'b0000; locAck = 1'b1; locDin = 16'h00C7;
    @(negedge clk);
    startStb = 1'b0; locAck = 1'b0; beN = 4'hF;
    chk("R11", "only done", 32'({doneP, abortP, noopP}), 32'b100);
    @(negedge clk);
    chk("R11", "ignored start", 32'({doneP, abortP, noopP, locStb}), 0);

    // R11: start accepted in the done cycle (back-to-back)
    narrowSel = 1'b0; wrEn = 1'b1; beN = 4'b1101; wrData = 32'h0000AB00; startStb = 1'b1;
    @(negedge clk);
    startStb = 1'b0; locAck = 1'b1;
    @(negedge clk);
    locAck = 1'b0;
    chk("R8", "done b2b", 32'(doneP), 1);
    narrowSel = 1'b1; beN = 4'b0111; wrData = 32'h9C000000; startStb = 1'b1;
    @(negedge clk);
    startStb = 1'b0; beN = 4'hF;
    chk("R11", "b2b launch", 32'({locStb, locAddr, locBhe, locDout}),
        32'({1'b1, 2'b11, 1'b1, 16'h009C}));
    chk("R8", "b2b done not stretched", 32'(doneP), 0);
    locAck = 1'b1;
    @(negedge clk);
    locAck = 1'b0;
    chk("R8", "b2b second done", 32'(doneP), 1);
    @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule